// File: doc/BRIEF.md
# Eight-Bit Dual-Compare Interval Timer

This block is one timer channel. An eight-bit counter advances on a tick taken from a free-running prescaler that divides the core clock. Control bits pick one of three tick rates, or stop the counter. Two compare values are checked each time the counter advances. A match on either value, or a wrap past 0xFF, raises a sticky status flag. A match can also send the counter back to zero, so the channel can generate periodic events.

Software reaches the channel through a byte-wide register port with a write strobe and a combinational read path. Software can clear the status flags but can never set them. Each flag drives an interrupt request line, and each line is gated by its own enable bit in the control register.

Top module: `timer8_top`

## Requirements
- R1: After reset, the control, status and counter registers read 0x00, both compare registers read 0xFF, and all three interrupt lines are low.
- R2: Control bits 2:0 pick the count rate. Value 1 advances the counter once every 8 core cycles, value 2 once every 64, and value 3 once every 8192.
- R3: For control bits 2:0 equal to 0, 4, 5, 6 or 7, the counter holds its value.
- R4: When an advance takes the counter from 0xFF to 0x00, status bit 5 (overflow) is set.
- R5: When an advance leaves the counter greater than or equal to compare A, status bit 6 is set. A counter value above compare A also sets it. Comparisons happen only on advances.
- R6: When an advance leaves the counter greater than or equal to compare B, status bit 7 is set.
- R7: Control bits 4:3 pick the clear source. Value 01 returns the counter to 0 on a compare-A match. Value 10 returns it to 0 on a compare-B match. Values 00 and 11 never clear it.
- R8: Writing 0 to status bit 7, 6 or 5 clears that flag. Writing 1 leaves the flag as it was, so software cannot set a flag. Status bits 4:0 are plain read/write storage.
- R9: Interrupt lines are irq_cmpb = status bit 7 AND control bit 7, irq_cmpa = status bit 6 AND control bit 6, and irq_ovf = status bit 5 AND control bit 5.
- R10: A write to the counter register takes priority over an advance or a clear in the same cycle. The counter takes the written value, and that cycle sets no flag.
- R11: Register addresses are 0 for control, 1 for status, 2 for compare A, 3 for compare B and 4 for the counter. Addresses 5 to 7 read 0x00. rd_data follows addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr |
| irq_cmpb | output | 1 | Compare-B request |
| irq_cmpa | output | 1 | Compare-A request |
| irq_ovf | output | 1 | Overflow request |

## Verification
The hardest case to reach is a counter write that lands on the exact core cycle in which the selected tick fires. The prescaler phase cannot be seen at the ports. To hit that cycle, the bench holds the write strobe high on the counter address for eight back-to-back cycles with the divide-by-8 rate running. One of those writes must then share its edge with a tick. After each edge, the counter is read back and must equal the written value. Tick rates are checked over whole multiples of the period, so the result does not depend on the prescaler phase.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 13;
    localparam int N_TAPS = 3;
    // log2 of each selectable divider; select value i+1 picks entry i
    localparam int TAP_EXP [N_TAPS] = '{3, 6, 13};
    localparam int SEL_W  = 3;

    // control register field positions
    localparam int CTL_SEL_LO = 0;
    localparam int CTL_CLR_LO = 3;
    localparam int CTL_IE_OVF = 5;
    localparam int CTL_IE_A   = 6;
    localparam int CTL_IE_B   = 7;

    // flag vector order: [0]=overflow, [1]=match A, [2]=match B
    localparam int N_FLAGS    = 3;
    localparam int STS_FLAG_LO = 5;

    typedef enum logic [1:0] {
        CLR_NEVER = 2'b00,
        CLR_ON_A  = 2'b01,
        CLR_ON_B  = 2'b10,
        CLR_NEVER_ALT = 2'b11
    } clr_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_STAT = 3'd1,
        RA_CMPA = 3'd2,
        RA_CMPB = 3'd3,
        RA_CNT  = 3'd4
    } reg_addr_e;

endpackage

// File: rtl/timer8_prescaler.sv
module timer8_prescaler
    import timer8_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int NT = N_TAPS
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [NT-1:0] tick
);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // one-cycle pulse whenever the low TAP_EXP bits are all ones
    generate
        for (genvar i = 0; i < NT; i++) begin : g_tap
            assign tick[i] = &pre_q[TAP_EXP[i]-1:0];
        end
    endgenerate

endmodule

// File: rtl/timer8_count_core.sv
module timer8_count_core
    import timer8_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NT = N_TAPS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NT-1:0]      tick,
    input  logic [SEL_W-1:0]   clk_sel,
    input  clr_mode_e          clr_mode,
    input  logic [DW-1:0]      cmp_a,
    input  logic [DW-1:0]      cmp_b,
    input  logic               cnt_we,
    input  logic               sts_we,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      cnt_q,
    output logic [N_FLAGS-1:0] flag_q,
    output logic               tick_taken
);

    logic               sel_tick;
    logic               wrap_hit;
    logic               a_hit;
    logic               b_hit;
    logic [DW-1:0]      stage_inc;
    logic [DW-1:0]      stage_a;
    logic [DW-1:0]      stage_b;
    logic [N_FLAGS-1:0] hw_set;
    logic [N_FLAGS-1:0] sw_keep;

    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (clk_sel == SEL_W'(i + 1)) begin
                sel_tick = tick[i];
            end
        end
    end

    assign tick_taken = sel_tick && !cnt_we;

    // advance, then compare A (optional clear), then compare B on the result
    always_comb begin
        wrap_hit  = (cnt_q == {DW{1'b1}});
        stage_inc = cnt_q + 1'b1;
        a_hit     = (stage_inc >= cmp_a);
        stage_a   = stage_inc;
        if (a_hit && clr_mode == CLR_ON_A) begin
            stage_a = '0;
        end
        b_hit   = (stage_a >= cmp_b);
        stage_b = stage_a;
        if (b_hit && clr_mode == CLR_ON_B) begin
            stage_b = '0;
        end
    end

    assign hw_set  = tick_taken ? {b_hit, a_hit, wrap_hit} : '0;
    assign sw_keep = sts_we ? wdata[STS_FLAG_LO +: N_FLAGS] : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= wdata;
        end else if (sel_tick) begin
            cnt_q <= stage_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & sw_keep) | hw_set;
        end
    end

endmodule

// File: rtl/timer8_regbank.sv
module timer8_regbank
    import timer8_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    input  logic [DW-1:0]      cnt_q,
    input  logic [N_FLAGS-1:0] flag_q,
    output logic [DW-1:0]      ctrl_q,
    output logic [DW-1:0]      cmpa_q,
    output logic [DW-1:0]      cmpb_q,
    output logic               cnt_we,
    output logic               sts_we,
    output logic [DW-1:0]      rd_data
);

    localparam int LO_W = STS_FLAG_LO;

    logic [LO_W-1:0] sts_lo_q;

    assign cnt_we = wr_en && (addr == RA_CNT);
    assign sts_we = wr_en && (addr == RA_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cmpa_q   <= '1;
            cmpb_q   <= '1;
            sts_lo_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                RA_CTRL: ctrl_q   <= wdata;
                RA_STAT: sts_lo_q <= wdata[LO_W-1:0];
                RA_CMPA: cmpa_q   <= wdata;
                RA_CMPB: cmpb_q   <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            RA_CTRL: rd_data = ctrl_q;
            RA_STAT: rd_data = {flag_q, sts_lo_q};
            RA_CMPA: rd_data = cmpa_q;
            RA_CMPB: rd_data = cmpb_q;
            RA_CNT:  rd_data = cnt_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/timer8_top.sv
module timer8_top
    import timer8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_cmpb,
    output logic              irq_cmpa,
    output logic              irq_ovf
);

    logic [N_TAPS-1:0]  tick_w;
    logic [DATA_W-1:0]  ctrl_w;
    logic [DATA_W-1:0]  cmpa_w;
    logic [DATA_W-1:0]  cmpb_w;
    logic [DATA_W-1:0]  cnt_w;
    logic [N_FLAGS-1:0] flag_w;
    logic               cnt_we_w;
    logic               sts_we_w;
    logic               tick_taken_w;
    logic [SEL_W-1:0]   clk_sel_w;
    clr_mode_e          clr_mode_w;

    assign clk_sel_w  = ctrl_w[CTL_SEL_LO +: SEL_W];
    assign clr_mode_w = clr_mode_e'(ctrl_w[CTL_CLR_LO +: 2]);

    timer8_prescaler #(.PW(PRE_W), .NT(N_TAPS)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_w)
    );

    timer8_regbank #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .cnt_q  (cnt_w),
        .flag_q (flag_w),
        .ctrl_q (ctrl_w),
        .cmpa_q (cmpa_w),
        .cmpb_q (cmpb_w),
        .cnt_we (cnt_we_w),
        .sts_we (sts_we_w),
        .rd_data(rd_data)
    );

    timer8_count_core #(.DW(DATA_W), .NT(N_TAPS)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .clk_sel   (clk_sel_w),
        .clr_mode  (clr_mode_w),
        .cmp_a     (cmpa_w),
        .cmp_b     (cmpb_w),
        .cnt_we    (cnt_we_w),
        .sts_we    (sts_we_w),
        .wdata     (wdata),
        .cnt_q     (cnt_w),
        .flag_q    (flag_w),
        .tick_taken(tick_taken_w)
    );

    assign irq_ovf  = flag_w[0] & ctrl_w[CTL_IE_OVF];
    assign irq_cmpa = flag_w[1] & ctrl_w[CTL_IE_A];
    assign irq_cmpb = flag_w[2] & ctrl_w[CTL_IE_B];

endmodule

// File: rtl/timer8_checker.sv
module timer8_checker
    import timer8_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  cnt,
    input logic [N_FLAGS-1:0] flags,
    input logic [SEL_W-1:0]   clk_sel,
    input logic               tick_taken
);

    logic cnt_wr;
    logic sel_stopped;

    assign cnt_wr      = wr_en && (addr == RA_CNT);
    assign sel_stopped = (clk_sel == 3'd0) || (clk_sel > 3'(N_TAPS));

    assert_cnt_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wdata)));

    assert_stopped_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && sel_stopped) |=> $stable(cnt));

    assert_cnt_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 8'd1 || cnt == 8'd0));

    assert_wrap_sets_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_taken && cnt == 8'hFF) |=> flags[0]);

    assert_match_a_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(tick_taken));

    assert_match_b_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(tick_taken));

    assert_ovf_clear_by_sw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[0]) |-> $past(wr_en && addr == RA_STAT && !wdata[STS_FLAG_LO]));

endmodule

bind timer8_top timer8_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .cnt       (cnt_w),
    .flags     (flag_w),
    .clk_sel   (clk_sel_w),
    .tick_taken(tick_taken_w)
);

// File: tb/sim_timer8_top.sv
module sim_timer8_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rd_data;
    logic       irq_cmpb;
    logic       irq_cmpa;
    logic       irq_ovf;

    int n_checks = 0;
    int n_fail = 0;

    timer8_top u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .irq_cmpb(irq_cmpb),
        .irq_cmpa(irq_cmpa),
        .irq_ovf (irq_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_check(input string req, input string what,
                              input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_read(a, v);
        check8(req, what, v, exp);
    endtask

    task automatic irq_check(input string req, input logic [2:0] exp);
        #1;
        check8(req, "irq {b,a,ovf}", {5'd0, irq_cmpb, irq_cmpa, irq_ovf}, {5'd0, exp});
    endtask

    task automatic t_reset();
        do_reset();
        read_check("R1", "ctrl",   3'd0, 8'h00);
        read_check("R1", "status", 3'd1, 8'h00);
        read_check("R1", "cmpA",   3'd2, 8'hFF);
        read_check("R1", "cmpB",   3'd3, 8'hFF);
        read_check("R1", "cnt",    3'd4, 8'h00);
        irq_check("R1", 3'b000);
        read_check("R11", "addr5", 3'd5, 8'h00);
    endtask

    task automatic t_regmap();
        do_reset();
        bus_write(3'd2, 8'h5A);
        bus_write(3'd3, 8'hA5);
        bus_write(3'd0, 8'h18);
        bus_write(3'd1, 8'h0A);
        read_check("R11", "cmpA", 3'd2, 8'h5A);
        read_check("R11", "cmpB", 3'd3, 8'hA5);
        read_check("R11", "ctrl", 3'd0, 8'h18);
        read_check("R8",  "status low bits", 3'd1, 8'h0A);
        read_check("R11", "addr6", 3'd6, 8'h00);
        read_check("R11", "addr7", 3'd7, 8'h00);
    endtask

    task automatic t_rates();
        do_reset();
        bus_write(3'd0, 8'h01);
        wait_cycles(40);
        read_check("R2", "div8 after 40", 3'd4, 8'd5);
        do_reset();
        bus_write(3'd0, 8'h02);
        wait_cycles(192);
        read_check("R2", "div64 after 192", 3'd4, 8'd3);
        do_reset();
        bus_write(3'd0, 8'h03);
        wait_cycles(16384);
        read_check("R2", "div8192 after 16384", 3'd4, 8'd2);
    endtask

    task automatic t_stop();
        do_reset();
        bus_write(3'd4, 8'h22);
        wait_cycles(60);
        read_check("R3", "sel0 hold", 3'd4, 8'h22);
        bus_write(3'd0, 8'h04);
        wait_cycles(100);
        read_check("R3", "sel4 hold", 3'd4, 8'h22);
        bus_write(3'd0, 8'h07);
        wait_cycles(100);
        read_check("R3", "sel7 hold", 3'd4, 8'h22);
    endtask

    task automatic t_overflow_flags_irq();
        do_reset();
        bus_write(3'd4, 8'hFD);
        bus_write(3'd0, 8'h01);
        wait_cycles(16);
        read_check("R4", "cnt before wrap", 3'd4, 8'hFF);
        read_check("R4", "no ovf before wrap", 3'd1, 8'hC0);
        wait_cycles(8);
        read_check("R4", "cnt after wrap", 3'd4, 8'h00);
        read_check("R4", "ovf set", 3'd1, 8'hE0);
        bus_write(3'd0, 8'h20);
        irq_check("R9", 3'b001);
        bus_write(3'd0, 8'hC0);
        irq_check("R9", 3'b110);
        bus_write(3'd0, 8'h00);
        irq_check("R9", 3'b000);
        bus_write(3'd1, 8'hDF);
        read_check("R8", "clear ovf only", 3'd1, 8'hDF);
        bus_write(3'd1, 8'h00);
        read_check("R8", "clear all", 3'd1, 8'h00);
        bus_write(3'd1, 8'hE0);
        read_check("R8", "write 1 cannot set", 3'd1, 8'h00);
        bus_write(3'd0, 8'hE0);
        irq_check("R9", 3'b000);
    endtask

    task automatic t_cmp_a_clear();
        do_reset();
        bus_write(3'd2, 8'h05);
        bus_write(3'd0, 8'h09);
        wait_cycles(32);
        read_check("R5", "cnt below A", 3'd4, 8'd4);
        read_check("R5", "no match yet", 3'd1, 8'h00);
        wait_cycles(8);
        read_check("R7", "cleared on A", 3'd4, 8'd0);
        read_check("R5", "match A flag", 3'd1, 8'h40);
        wait_cycles(16);
        read_check("R7", "counts after clear", 3'd4, 8'd2);
    endtask

    task automatic t_cmp_a_ge();
        do_reset();
        bus_write(3'd2, 8'h08);
        bus_write(3'd4, 8'h10);
        read_check("R5", "no compare without tick", 3'd1, 8'h00);
        bus_write(3'd0, 8'h01);
        wait_cycles(8);
        read_check("R5", "cnt above A", 3'd4, 8'h11);
        read_check("R5", "ge sets A", 3'd1, 8'h40);
    endtask

    task automatic t_cmp_b();
        do_reset();
        bus_write(3'd3, 8'h03);
        bus_write(3'd0, 8'h11);
        wait_cycles(24);
        read_check("R7", "cleared on B", 3'd4, 8'd0);
        read_check("R6", "match B flag", 3'd1, 8'h80);
        do_reset();
        bus_write(3'd3, 8'h03);
        bus_write(3'd0, 8'h19);
        wait_cycles(24);
        read_check("R7", "mode 11 no clear", 3'd4, 8'd3);
        read_check("R6", "match B flag", 3'd1, 8'h80);
        wait_cycles(8);
        read_check("R7", "keeps counting", 3'd4, 8'd4);
    endtask

    task automatic t_write_priority();
        logic [7:0] v;
        do_reset();
        bus_write(3'd0, 8'h01);
        @(negedge clk);
        addr  = 3'd4;
        wdata = 8'h40;
        wr_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #1;
            v = rd_data;
            check8("R10", "write vs tick", v, 8'h40);
        end
        wr_en = 1'b0;
        wait_cycles(8);
        read_check("R10", "resumes from written", 3'd4, 8'h41);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_regmap();
        t_rates();
        t_stop();
        t_overflow_flags_irq();
        t_cmp_a_clear();
        t_cmp_a_ge();
        t_cmp_b();
        t_write_priority();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule